// File: doc/BRIEF.md
# Backup Memory Type Auto-Detector

This block works out which kind of battery-backed save memory sits behind a cartridge slot and holds that answer in a register. It starts out not knowing the type. It decides the type from the first access that commits to one. A DMA burst to the serial EEPROM window picks an EEPROM size from the burst length. A byte write to the backup window picks flash or SRAM from the address written. A flash write also uses a flag that says a large-flash signature was found in the program image.

Software or a loader can also set the type directly from a save image size. Accesses that conflict with the type already held raise a one-cycle error pulse. The held type does not change on an error. Reset returns the block to the unknown type.

Top module: `backup_kind_detect`

## Requirements
- R1: With the type unknown (code 0), an EEPROM DMA of 17 or 81 units sets the type to code 2 (EEPROM 8 KiB), and one of 9 or 73 units sets it to code 1 (EEPROM 512 B).
- R2: An EEPROM DMA whose length is not 9, 17, 73 or 81 raises the error pulse.
- R3: An EEPROM DMA while the type is SRAM (code 3) or flash (codes 4, 5) raises the error pulse.
- R4: With an EEPROM type held, a DMA whose length class belongs to the other EEPROM size raises the error pulse. A DMA of the matching class is accepted without error.
- R5: With the type unknown, a backup write to address 0x5555 selects flash: 128 KiB (code 5) when big_sig_i is 1, otherwise 64 KiB (code 4). A write to any other address selects SRAM (code 3).
- R6: A backup write while an EEPROM type (code 1 or 2) is held raises the error pulse.
- R7: A size load maps 0x200 to code 1, 0x2000 to code 2, 0x8000 to code 3, 0x10000 to code 4 and 0x20000 to code 5. It replaces any held type. Any other size raises the error pulse.
- R8: Reset sets the type to code 0 and clears the error output. The type code never exceeds 5.
- R9: Once a type other than unknown is held, only a size load can change it. Backup writes to SRAM or flash have no effect on the type and raise no error.
- R10: When events coincide in one cycle, a size load takes priority over a DMA, and a DMA takes priority over a write. The lower-priority events in that cycle are ignored.
- R11: The error output is high for exactly the cycle after the offending event. The type is unchanged across an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_evt_i | input | 1 | EEPROM DMA transfer event |
| dma_len_i | input | LEN_W | Length of that transfer in units |
| wr_evt_i | input | 1 | Byte write to the backup window |
| wr_addr_i | input | ADDR_W | Address of that write |
| big_sig_i | input | 1 | Large-flash signature present |
| load_evt_i | input | 1 | Explicit size-based type load |
| load_size_i | input | SIZE_W | Save image size in bytes |
| kind_o | output | 3 | Held type code (0 unknown, 1 EEPROM 512 B, 2 EEPROM 8 KiB, 3 SRAM, 4 flash 64 KiB, 5 flash 128 KiB) |
| err_o | output | 1 | Error pulse |

## Verification
The type register is the only state, and kind_o shows it directly one cycle after any event. A wrong internal type therefore shows at the port right away. It also changes how later events are judged. For example, a type wrongly left unknown lets a later write pick SRAM, and a wrongly held EEPROM type makes a later write raise err_o. The tests therefore follow each latching event with a second event whose error response depends on the held type. A corrupted type then shows within two cycles.

// File: rtl/bkd_pkg.sv
package bkd_pkg;

    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_EE_SMALL = 3'd1,
        KIND_EE_LARGE = 3'd2,
        KIND_SRAM     = 3'd3,
        KIND_FL_SMALL = 3'd4,
        KIND_FL_LARGE = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        LC_BAD   = 2'd0,
        LC_SMALL = 2'd1,
        LC_LARGE = 2'd2
    } len_class_e;

    typedef struct packed {
        kind_e kind;
        logic  err;
    } det_state_t;

    function automatic logic kind_is_eeprom(kind_e k);
        return (k == KIND_EE_SMALL) || (k == KIND_EE_LARGE);
    endfunction

endpackage

// File: rtl/bkd_dma_class.sv
module bkd_dma_class
    import bkd_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SMALL_A   = 9,
    parameter int SMALL_B   = 73,
    parameter int LARGE_A   = 17,
    parameter int LARGE_B   = 81
) (
    input  logic [LEN_W-1:0] len_i,
    output len_class_e       cls_o
);
    localparam logic [LEN_W-1:0] S_A = LEN_W'(SMALL_A);
    localparam logic [LEN_W-1:0] S_B = LEN_W'(SMALL_B);
    localparam logic [LEN_W-1:0] L_A = LEN_W'(LARGE_A);
    localparam logic [LEN_W-1:0] L_B = LEN_W'(LARGE_B);

    always_comb begin
        if (len_i == L_A || len_i == L_B) begin
            cls_o = LC_LARGE;
        end else if (len_i == S_A || len_i == S_B) begin
            cls_o = LC_SMALL;
        end else begin
            cls_o = LC_BAD;
        end
    end
endmodule

// File: rtl/bkd_size_map.sv
module bkd_size_map
    import bkd_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic              ok_o,
    output kind_e             kind_o
);
    localparam logic [SIZE_W-1:0] SZ_EE_SMALL = SIZE_W'(32'h0000_0200);
    localparam logic [SIZE_W-1:0] SZ_EE_LARGE = SIZE_W'(32'h0000_2000);
    localparam logic [SIZE_W-1:0] SZ_SRAM     = SIZE_W'(32'h0000_8000);
    localparam logic [SIZE_W-1:0] SZ_FL_SMALL = SIZE_W'(32'h0001_0000);
    localparam logic [SIZE_W-1:0] SZ_FL_LARGE = SIZE_W'(32'h0002_0000);

    always_comb begin
        ok_o   = 1'b1;
        kind_o = KIND_NONE;
        if (size_i == SZ_EE_SMALL) begin
            kind_o = KIND_EE_SMALL;
        end else if (size_i == SZ_EE_LARGE) begin
            kind_o = KIND_EE_LARGE;
        end else if (size_i == SZ_SRAM) begin
            kind_o = KIND_SRAM;
        end else if (size_i == SZ_FL_SMALL) begin
            kind_o = KIND_FL_SMALL;
        end else if (size_i == SZ_FL_LARGE) begin
            kind_o = KIND_FL_LARGE;
        end else begin
            ok_o = 1'b0;
        end
    end
endmodule

// File: rtl/bkd_write_pick.sv
module bkd_write_pick
    import bkd_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int FLASH_CMD_ADDR = 16'h5555
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              big_sig_i,
    output kind_e             kind_o
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(FLASH_CMD_ADDR);

    always_comb begin
        if (addr_i != CMD_ADDR) begin
            kind_o = KIND_SRAM;
        end else if (big_sig_i) begin
            kind_o = KIND_FL_LARGE;
        end else begin
            kind_o = KIND_FL_SMALL;
        end
    end
endmodule

// File: rtl/backup_kind_detect.sv
module backup_kind_detect
    import bkd_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_evt_i,
    input  logic [LEN_W-1:0]  dma_len_i,
    input  logic              wr_evt_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              big_sig_i,
    input  logic              load_evt_i,
    input  logic [SIZE_W-1:0] load_size_i,
    output logic [2:0]        kind_o,
    output logic              err_o
);
    localparam logic [LEN_W-1:0]  LEN_9    = LEN_W'(9);
    localparam logic [LEN_W-1:0]  LEN_17   = LEN_W'(17);
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(16'h5555);

    len_class_e dma_cls;
    logic       size_ok;
    kind_e      size_kind;
    kind_e      wr_kind;
    det_state_t st_d, st_q;

    bkd_dma_class #(.LEN_W(LEN_W)) u_dma_class (
        .len_i (dma_len_i),
        .cls_o (dma_cls)
    );

    bkd_size_map #(.SIZE_W(SIZE_W)) u_size_map (
        .size_i (load_size_i),
        .ok_o   (size_ok),
        .kind_o (size_kind)
    );

    bkd_write_pick #(.ADDR_W(ADDR_W)) u_write_pick (
        .addr_i    (wr_addr_i),
        .big_sig_i (big_sig_i),
        .kind_o    (wr_kind)
    );

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        if (load_evt_i) begin
            if (size_ok) begin
                st_d.kind = size_kind;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (dma_evt_i) begin
            unique case (st_q.kind)
                KIND_NONE: begin
                    if (dma_cls == LC_LARGE) begin
                        st_d.kind = KIND_EE_LARGE;
                    end else if (dma_cls == LC_SMALL) begin
                        st_d.kind = KIND_EE_SMALL;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                KIND_EE_SMALL: st_d.err = (dma_cls != LC_SMALL);
                KIND_EE_LARGE: st_d.err = (dma_cls != LC_LARGE);
                default:       st_d.err = 1'b1;
            endcase
        end else if (wr_evt_i) begin
            if (st_q.kind == KIND_NONE) begin
                st_d.kind = wr_kind;
            end else if (kind_is_eeprom(st_q.kind)) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{kind: KIND_NONE, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o = st_q.kind;
    assign err_o  = st_q.err;

    a_r8_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        kind_o <= 3'd5);

    a_r11_err_keeps_kind: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (kind_o == $past(kind_o)));

    a_r9_held_type_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o != 3'd0 && !load_evt_i) |=> $stable(kind_o));

    a_r1_large_burst_picks: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd0 && dma_evt_i && !load_evt_i && dma_len_i == LEN_17)
        |=> (kind_o == 3'd2 && !err_o));

    a_r1_small_burst_picks: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd0 && dma_evt_i && !load_evt_i && dma_len_i == LEN_9)
        |=> (kind_o == 3'd1 && !err_o));

    a_r5_flash_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd0 && wr_evt_i && !dma_evt_i && !load_evt_i && wr_addr_i == CMD_ADDR)
        |=> (kind_o == (big_sig_i ? 3'd5 : 3'd4) || kind_o == $past(big_sig_i ? 3'd5 : 3'd4)));

    a_r6_write_on_eeprom: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind_o == 3'd1 || kind_o == 3'd2) && wr_evt_i && !dma_evt_i && !load_evt_i)
        |=> err_o);

    a_r3_dma_on_nonvolatile: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o >= 3'd3 && dma_evt_i && !load_evt_i) |=> err_o);
endmodule

// File: tb/backup_kind_detect_bench.sv
module backup_kind_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_evt = 1'b0;
    logic [15:0] dma_len = '0;
    logic        wr_evt = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        big_sig = 1'b0;
    logic        load_evt = 1'b0;
    logic [19:0] load_size = '0;
    logic [2:0]  kind;
    logic        err;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    backup_kind_detect u_backup_kind_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_evt_i   (dma_evt),
        .dma_len_i   (dma_len),
        .wr_evt_i    (wr_evt),
        .wr_addr_i   (wr_addr),
        .big_sig_i   (big_sig),
        .load_evt_i  (load_evt),
        .load_size_i (load_size),
        .kind_o      (kind),
        .err_o       (err)
    );

    task automatic check(string req, logic [2:0] k_exp, logic e_exp);
        n_checks++;
        if (kind !== k_exp || err !== e_exp) begin
            n_fail++;
            $display("FAIL %s: kind=%0d err=%0b expected kind=%0d err=%0b",
                     req, kind, err, k_exp, e_exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic dma(int len);
        @(negedge clk);
        dma_evt = 1'b1; dma_len = 16'(len);
        @(negedge clk);
        dma_evt = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic sig);
        @(negedge clk);
        wr_evt = 1'b1; wr_addr = a; big_sig = sig;
        @(negedge clk);
        wr_evt = 1'b0; big_sig = 1'b0;
    endtask

    task automatic load(logic [19:0] sz);
        @(negedge clk);
        load_evt = 1'b1; load_size = sz;
        @(negedge clk);
        load_evt = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R8 reset", 3'd0, 1'b0);
    endtask

    task automatic t_dma_pick();
        do_reset(); dma(17); check("R1 len17", 3'd2, 1'b0);
        do_reset(); dma(81); check("R1 len81", 3'd2, 1'b0);
        do_reset(); dma(9);  check("R1 len9", 3'd1, 1'b0);
        do_reset(); dma(73); check("R1 len73", 3'd1, 1'b0);
    endtask

    task automatic t_dma_bad_len();
        do_reset(); dma(10); check("R2 len10", 3'd0, 1'b1);
        idle(); check("R11 pulse ends", 3'd0, 1'b0);
        dma(0); check("R2 len0", 3'd0, 1'b1);
    endtask

    task automatic t_dma_on_sram();
        do_reset(); wr(16'h1234, 1'b0); check("R5 other addr sram", 3'd3, 1'b0);
        dma(9); check("R3 dma on sram", 3'd3, 1'b1);
        do_reset(); wr(16'h5555, 1'b1); dma(17); check("R3 dma on flash", 3'd5, 1'b1);
    endtask

    task automatic t_dma_mismatch();
        do_reset(); dma(9);
        dma(17); check("R4 large on small", 3'd1, 1'b1);
        dma(73); check("R4 matching small", 3'd1, 1'b0);
        do_reset(); dma(81);
        dma(9); check("R4 small on large", 3'd2, 1'b1);
        dma(20); check("R4 bad on large", 3'd2, 1'b1);
    endtask

    task automatic t_write_pick();
        do_reset(); wr(16'h5555, 1'b0); check("R5 flash64", 3'd4, 1'b0);
        do_reset(); wr(16'h5555, 1'b1); check("R5 flash128", 3'd5, 1'b0);
        do_reset(); wr(16'h0000, 1'b1); check("R5 addr0 sram", 3'd3, 1'b0);
    endtask

    task automatic t_write_on_eeprom();
        do_reset(); dma(17); wr(16'h0010, 1'b0); check("R6 write on ee8k", 3'd2, 1'b1);
        do_reset(); dma(9); wr(16'h5555, 1'b1); check("R6 write on ee512", 3'd1, 1'b1);
    endtask

    task automatic t_load();
        do_reset(); load(20'h00200); check("R7 0x200", 3'd1, 1'b0);
        load(20'h02000); check("R7 0x2000", 3'd2, 1'b0);
        load(20'h08000); check("R7 0x8000", 3'd3, 1'b0);
        load(20'h10000); check("R7 0x10000", 3'd4, 1'b0);
        load(20'h20000); check("R7 0x20000", 3'd5, 1'b0);
        load(20'h04000); check("R7 bad size", 3'd5, 1'b1);
        do_reset(); check("R8 reset after flash", 3'd0, 1'b0);
    endtask

    task automatic t_sticky();
        do_reset(); wr(16'h2000, 1'b0);
        wr(16'h5555, 1'b1); check("R9 sram holds", 3'd3, 1'b0);
        do_reset(); wr(16'h5555, 1'b0);
        wr(16'h0001, 1'b0); check("R9 flash holds", 3'd4, 1'b0);
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk);
        load_evt = 1'b1; load_size = 20'h08000; dma_evt = 1'b1; dma_len = 16'd17;
        wr_evt = 1'b1; wr_addr = 16'h5555;
        @(negedge clk);
        load_evt = 1'b0; dma_evt = 1'b0; wr_evt = 1'b0;
        check("R10 load wins", 3'd3, 1'b0);
        do_reset();
        @(negedge clk);
        dma_evt = 1'b1; dma_len = 16'd9; wr_evt = 1'b1; wr_addr = 16'h5555;
        @(negedge clk);
        dma_evt = 1'b0; wr_evt = 1'b0;
        check("R10 dma over write", 3'd1, 1'b0);
        idle(); check("R10 write ignored", 3'd1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_dma_pick();
        t_dma_bad_len();
        t_dma_on_sram();
        t_dma_mismatch();
        t_write_pick();
        t_write_on_eeprom();
        t_load();
        t_sticky();
        t_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule